// File: doc/BRIEF.md
# Receive Frame Size Check and Statistics

This block sits after the receive address filter of an Ethernet MAC. It looks at every frame the filter has accepted, once, when the frame ends. First it decides whether the frame is too long to keep. An oversized frame is flagged for dropping, and only the oversize tally records it. Any other frame is counted by a set of saturating statistics counters:

- a six-bin length histogram;
- total and good packet counts;
- total and good octet sums, each 64 bits wide;
- broadcast and multicast counts.

The broadcast and multicast counters are chosen from the destination address itself. Which filter accepted the frame plays no part, so one frame can never be counted twice.

Software or a neighbouring register block reads the counters through an indexed port. Each index selects one 32-bit word. The read is combinational from the registered counter state. An update caused by a frame becomes visible one cycle after the frame-done strobe.

Top module: `rx_size_stats`

## Requirements
- R1: A frame is oversized when its length (FCS excluded) is above 16384, or above 1522 while `long_pkt_en` is 0. No frame is oversized while `store_bad_pkt` is 1.
- R2: `drop_o` is 1 in exactly the cycle after a `frame_done` strobe that carried an oversized frame, and 0 otherwise. Such a frame adds one to the oversize counter (word 10) and changes no other counter.
- R3: The histogram uses length+4. Word 0 counts exactly 64, word 1 counts 65..127, word 2 counts 128..255, word 3 counts 256..511, word 4 counts 512..1023 and word 5 counts above 1023. A value below 64 touches no bin.
- R4: Every counter stops at its all-ones value instead of wrapping.
- R5: Each counted frame adds one to the total-packet counter (word 6) and to the good-packet counter (word 7).
- R6: The two 64-bit octet counters each grow by length+4 per counted frame. The total sum reads as words 11 (low) and 12 (high). The good sum reads as words 13 (low) and 14 (high).
- R7: `dst_all_ones`=1 makes a frame broadcast (word 8). Otherwise, bit 0 of `dst_first_byte` set makes it multicast (word 9). A frame counts in at most one of the two.
- R8: After reset every counter reads zero and `drop_o` is 0.
- R9: `rd_data` returns the word selected by `rd_idx`. Counter widths below 32 are zero-extended, and index 15 reads zero.
- R10: A read in the cycle of a `frame_done` strobe returns the value from before that frame. The new value is readable from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe at the end of an accepted frame |
| frame_len | input | LEN_W | Frame length in bytes without FCS |
| dst_first_byte | input | 8 | First byte of the destination address |
| dst_all_ones | input | 1 | Destination address is all ones |
| long_pkt_en | input | 1 | Raise the length limit to the jumbo limit |
| store_bad_pkt | input | 1 | Keep every frame regardless of length |
| drop_o | output | 1 | Oversized frame, drop it (one cycle after the strobe) |
| rd_idx | input | 4 | Counter word index |
| rd_data | output | 32 | Selected counter word |

## Verification
The counter update and the read port can act in the same cycle. The bench strobes a frame while already selecting the total-packet word. It expects the pre-frame value combinationally in that cycle and the incremented value just after the clock edge.

A second collision is between saturation and ordinary counting. A narrow-width instance runs the same frame stream as the default one. Its packet and octet counters must freeze at all-ones while the wide instance keeps counting.

// File: rtl/rxst_pkg.sv
package rxst_pkg;
    // counter word layout as seen through the read port
    localparam int NUM_BINS  = 6;
    localparam int NUM_CNT   = 11;
    localparam int IDX_TOT   = 6;
    localparam int IDX_GOOD  = 7;
    localparam int IDX_BC    = 8;
    localparam int IDX_MC    = 9;
    localparam int IDX_OVS   = 10;
    localparam int W_TOCT_LO = 11;
    localparam int W_TOCT_HI = 12;
    localparam int W_GOCT_LO = 13;
    localparam int W_GOCT_HI = 14;
    localparam int RD_IDX_W  = 4;
    localparam int RD_W      = 32;
    localparam int FCS_BYTES = 4;
endpackage

// File: rtl/rxst_sat_add.sv
module rxst_sat_add #(
    parameter int W  = 32,
    parameter int IW = 1
) (
    input  logic [W-1:0]  a,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  y
);
    localparam int SW = ((W > IW) ? W : IW) + 1;

    logic [SW-1:0] sum;
    logic [SW-1:0] lim;

    assign sum = SW'(a) + SW'(inc);
    assign lim = SW'({W{1'b1}});
    assign y   = (sum > lim) ? {W{1'b1}} : sum[W-1:0];
endmodule

// File: rtl/rxst_classify.sv
module rxst_classify
    import rxst_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 16384
) (
    input  logic [LEN_W-1:0]    len,
    input  logic [7:0]          dst_first_byte,
    input  logic                dst_all_ones,
    input  logic                long_pkt_en,
    input  logic                store_bad_pkt,
    output logic                oversize,
    output logic [NUM_BINS-1:0] bin_hit,
    output logic                is_bcast,
    output logic                is_mcast,
    output logic [LEN_W:0]      len_fcs
);
    localparam int LFW = LEN_W + 1;
    localparam logic [LFW-1:0] STD_L   = LFW'(STD_MAX);
    localparam logic [LFW-1:0] JUMBO_L = LFW'(JUMBO_MAX);

    logic [LFW-1:0] len_x;

    assign len_x   = {1'b0, len};
    assign len_fcs = len_x + LFW'(FCS_BYTES);

    assign oversize = !store_bad_pkt &&
                      ((len_x > JUMBO_L) || (!long_pkt_en && (len_x > STD_L)));

    // bin b covers [lo, hi]; bin 0 is exactly 64, the last bin is open-ended
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
        localparam int LO = (b == 0) ? 64 : ((b == 1) ? 65 : (64 << (b - 1)));
        localparam int HI = (b == 0) ? 64 : ((64 << b) - 1);
        if (b == NUM_BINS - 1) begin : g_open
            assign bin_hit[b] = (len_fcs >= LFW'(LO));
        end else begin : g_closed
            assign bin_hit[b] = (len_fcs >= LFW'(LO)) && (len_fcs <= LFW'(HI));
        end
    end

    assign is_bcast = dst_all_ones;
    assign is_mcast = !dst_all_ones && dst_first_byte[0];
endmodule

// File: rtl/rx_size_stats.sv
module rx_size_stats
    import rxst_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter int OCT_W     = 64,
    parameter int STD_MAX   = 1522,
    parameter int JUMBO_MAX = 16384
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  logic [LEN_W-1:0]    frame_len,
    input  logic [7:0]          dst_first_byte,
    input  logic                dst_all_ones,
    input  logic                long_pkt_en,
    input  logic                store_bad_pkt,
    output logic                drop_o,
    input  logic [RD_IDX_W-1:0] rd_idx,
    output logic [RD_W-1:0]     rd_data
);
    localparam int LFW = LEN_W + 1;

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
        logic [1:0][OCT_W-1:0]         oct;
        logic                          drop;
    } state_t;

    state_t st_d, st_q;

    logic                          oversize;
    logic [NUM_BINS-1:0]           bin_hit;
    logic                          is_bcast;
    logic                          is_mcast;
    logic [LFW-1:0]                len_fcs;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_inc;
    logic [1:0][OCT_W-1:0]         oct_inc;

    rxst_classify #(
        .LEN_W    (LEN_W),
        .STD_MAX  (STD_MAX),
        .JUMBO_MAX(JUMBO_MAX)
    ) u_cls (
        .len           (frame_len),
        .dst_first_byte(dst_first_byte),
        .dst_all_ones  (dst_all_ones),
        .long_pkt_en   (long_pkt_en),
        .store_bad_pkt (store_bad_pkt),
        .oversize      (oversize),
        .bin_hit       (bin_hit),
        .is_bcast      (is_bcast),
        .is_mcast      (is_mcast),
        .len_fcs       (len_fcs)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_inc
        rxst_sat_add #(.W(CNT_W), .IW(1)) u_inc (
            .a  (st_q.cnt[i]),
            .inc(1'b1),
            .y  (cnt_inc[i])
        );
    end

    for (genvar k = 0; k < 2; k++) begin : g_oct_inc
        rxst_sat_add #(.W(OCT_W), .IW(LFW)) u_inc (
            .a  (st_q.oct[k]),
            .inc(len_fcs),
            .y  (oct_inc[k])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.drop = 1'b0;
        if (frame_done) begin
            if (oversize) begin
                st_d.drop         = 1'b1;
                st_d.cnt[IDX_OVS] = cnt_inc[IDX_OVS];
            end else begin
                for (int b = 0; b < NUM_BINS; b++) begin
                    if (bin_hit[b]) st_d.cnt[b] = cnt_inc[b];
                end
                st_d.cnt[IDX_TOT]  = cnt_inc[IDX_TOT];
                st_d.cnt[IDX_GOOD] = cnt_inc[IDX_GOOD];
                if (is_bcast) st_d.cnt[IDX_BC] = cnt_inc[IDX_BC];
                if (is_mcast) st_d.cnt[IDX_MC] = cnt_inc[IDX_MC];
                st_d.oct = oct_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drop_o = st_q.drop;

    logic [1:0][63:0] oct_ext;
    assign oct_ext[0] = 64'(st_q.oct[0]);
    assign oct_ext[1] = 64'(st_q.oct[1]);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (rd_idx == RD_IDX_W'(i)) rd_data = RD_W'(st_q.cnt[i]);
        end
        if (rd_idx == RD_IDX_W'(W_TOCT_LO)) rd_data = oct_ext[0][31:0];
        if (rd_idx == RD_IDX_W'(W_TOCT_HI)) rd_data = oct_ext[0][63:32];
        if (rd_idx == RD_IDX_W'(W_GOCT_LO)) rd_data = oct_ext[1][31:0];
        if (rd_idx == RD_IDX_W'(W_GOCT_HI)) rd_data = oct_ext[1][63:32];
    end
endmodule

// File: rtl/rxst_chk.sv
module rxst_chk
    import rxst_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int CNT_W     = 32,
    parameter int JUMBO_MAX = 16384
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     frame_done,
    input logic [LEN_W-1:0]         frame_len,
    input logic                     store_bad_pkt,
    input logic                     drop_o,
    input logic [NUM_CNT*CNT_W-1:0] cnt_flat
);
    localparam logic [LEN_W:0] JUMBO_L = (LEN_W + 1)'(JUMBO_MAX);

    // R2
    drop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> $past(frame_done));

    // R1
    keep_bad_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && store_bad_pkt) |=> !drop_o);

    // R1
    jumbo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !store_bad_pkt && ({1'b0, frame_len} > JUMBO_L)) |=> drop_o);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(cnt_flat));

    // R4
    good_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (cnt_flat[IDX_GOOD*CNT_W +: CNT_W] >=
                        $past(cnt_flat[IDX_GOOD*CNT_W +: CNT_W])));
endmodule

bind rx_size_stats rxst_chk #(
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .JUMBO_MAX(JUMBO_MAX)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_done   (frame_done),
    .frame_len    (frame_len),
    .store_bad_pkt(store_bad_pkt),
    .drop_o       (drop_o),
    .cnt_flat     (st_q.cnt)
);

// File: tb/sim_rx_size_stats.sv
module sim_rx_size_stats;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_done = 1'b0;
    logic [15:0] frame_len = '0;
    logic [7:0]  dst_first_byte = '0;
    logic        dst_all_ones = 1'b0;
    logic        long_pkt_en = 1'b0;
    logic        store_bad_pkt = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic        drop0, drop1;
    logic [31:0] rd0, rd1;

    int nchecks = 0;
    int nerr = 0;
    bit done_flag = 0;

    // model: instance 0 wide, instance 1 narrow
    longint unsigned m_cnt [2][11];
    longint unsigned m_oct [2][2];
    longint unsigned mx_cnt [2];
    longint unsigned mx_oct [2];
    bit exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_size_stats u0 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
        .dst_first_byte(dst_first_byte), .dst_all_ones(dst_all_ones),
        .long_pkt_en(long_pkt_en), .store_bad_pkt(store_bad_pkt),
        .drop_o(drop0), .rd_idx(rd_idx), .rd_data(rd0)
    );

    rx_size_stats #(.CNT_W(4), .OCT_W(16)) u1 (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_len(frame_len),
        .dst_first_byte(dst_first_byte), .dst_all_ones(dst_all_ones),
        .long_pkt_en(long_pkt_en), .store_bad_pkt(store_bad_pkt),
        .drop_o(drop1), .rd_idx(rd_idx), .rd_data(rd1)
    );

    task automatic chk(input bit ok, input string req, input longint unsigned act,
                       input longint unsigned exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unsigned sat(input longint unsigned v,
                                            input longint unsigned inc,
                                            input longint unsigned mx);
        return (mx - v < inc) ? mx : v + inc;
    endfunction

    function automatic int bin_of(input int l);
        if (l == 64)   return 0;
        if (l < 64)    return -1;
        if (l <= 127)  return 1;
        if (l <= 255)  return 2;
        if (l <= 511)  return 3;
        if (l <= 1023) return 4;
        return 5;
    endfunction

    function automatic bit is_over(input int len, input bit lpe, input bit sbp);
        return !sbp && (len > 16384 || (len > 1522 && !lpe));
    endfunction

    task automatic model_frame(input int len, input bit b0, input bit all1,
                               input bit lpe, input bit sbp);
        for (int k = 0; k < 2; k++) begin
            if (is_over(len, lpe, sbp)) begin
                m_cnt[k][10] = sat(m_cnt[k][10], 1, mx_cnt[k]);
            end else begin
                if (bin_of(len + 4) >= 0)
                    m_cnt[k][bin_of(len + 4)] = sat(m_cnt[k][bin_of(len + 4)], 1, mx_cnt[k]);
                m_cnt[k][6] = sat(m_cnt[k][6], 1, mx_cnt[k]);
                m_cnt[k][7] = sat(m_cnt[k][7], 1, mx_cnt[k]);
                if (all1)    m_cnt[k][8] = sat(m_cnt[k][8], 1, mx_cnt[k]);
                else if (b0) m_cnt[k][9] = sat(m_cnt[k][9], 1, mx_cnt[k]);
                m_oct[k][0] = sat(m_oct[k][0], longint'(len + 4), mx_oct[k]);
                m_oct[k][1] = sat(m_oct[k][1], longint'(len + 4), mx_oct[k]);
            end
        end
    endtask

    task automatic drive(input int len, input logic [7:0] b0, input bit all1,
                         input bit lpe, input bit sbp);
        frame_len      = 16'(len);
        dst_first_byte = b0;
        dst_all_ones   = all1;
        long_pkt_en    = lpe;
        store_bad_pkt  = sbp;
        frame_done     = 1'b1;
        exp_q.push_back(is_over(len, lpe, sbp));
    endtask

    task automatic send(input int len, input logic [7:0] b0, input bit all1,
                        input bit lpe, input bit sbp);
        @(negedge clk);
        drive(len, b0, all1, lpe, sbp);
        model_frame(len, b0[0], all1, lpe, sbp);
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    function automatic longint unsigned word_exp(input int k, input int w);
        if (w <= 10) return m_cnt[k][w];
        if (w == 11) return m_oct[k][0] & 64'hFFFF_FFFF;
        if (w == 12) return m_oct[k][0] >> 32;
        if (w == 13) return m_oct[k][1] & 64'hFFFF_FFFF;
        if (w == 14) return m_oct[k][1] >> 32;
        return 0;
    endfunction

    function automatic string word_req(input int w);
        if (w <= 5)  return "R3 hist";
        if (w <= 7)  return "R5 pkts";
        if (w <= 9)  return "R7 cast";
        if (w == 10) return "R2 ovs";
        if (w <= 14) return "R6 octets";
        return "R9 idx15";
    endfunction

    task automatic read_all(input string tag);
        for (int w = 0; w < 16; w++) begin
            @(negedge clk);
            rd_idx = 4'(w);
            #1;
            chk(rd0 == 32'(word_exp(0, w)), (tag != "") ? tag : word_req(w),
                rd0, word_exp(0, w));
            chk(rd1 == 32'(word_exp(1, w)), (tag != "") ? tag : "R4 narrow",
                rd1, word_exp(1, w));
        end
    endtask

    // monitor: compare drop flags against the scoreboard queue
    initial begin
        bit e;
        forever begin
            @(posedge clk);
            if (rst_n && frame_done) begin
                #1;
                e = exp_q.pop_front();
                chk(drop0 == e, "R2 drop", drop0, e);
                chk(drop1 == e, "R2 drop narrow", drop1, e);
            end else if (rst_n) begin
                #1;
                chk(drop0 == 1'b0, "R2 idle drop", drop0, 0);
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nchecks++;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        mx_cnt[0] = 64'hFFFF_FFFF;
        mx_oct[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        mx_cnt[1] = 15;
        mx_oct[1] = 65535;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 11; i++) m_cnt[k][i] = 0;
            m_oct[k][0] = 0;
            m_oct[k][1] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(drop0 == 1'b0, "R8 drop", drop0, 0);
        read_all("R8 reset");

        // R3 histogram edges (len+4)
        send(60, 8'h02, 0, 0, 0);
        send(59, 8'h02, 0, 0, 0);
        send(61, 8'h02, 0, 0, 0);
        send(123, 8'h02, 0, 0, 0);
        send(124, 8'h02, 0, 0, 0);
        send(251, 8'h02, 0, 0, 0);
        send(508, 8'h02, 0, 0, 0);
        send(1019, 8'h02, 0, 0, 0);
        send(1020, 8'h02, 0, 0, 0);
        // R7 classification
        send(100, 8'hFF, 1, 0, 0);
        send(100, 8'h01, 0, 0, 0);
        send(100, 8'hFF, 0, 0, 0);
        // R1 length limits
        send(1522, 8'h00, 0, 0, 0);
        send(1523, 8'h00, 0, 0, 0);
        send(1523, 8'h00, 0, 1, 0);
        send(16384, 8'h00, 0, 1, 0);
        send(16385, 8'h00, 0, 1, 0);
        send(16385, 8'h01, 0, 1, 1);
        send(30000, 8'h00, 1, 0, 1);
        read_all("");

        // R10 read in the same cycle as an update
        @(negedge clk);
        rd_idx = 4'(6);
        drive(200, 8'h00, 0, 0, 0);
        #1;
        chk(rd0 == 32'(m_cnt[0][6]), "R10 same-cycle old", rd0, m_cnt[0][6]);
        model_frame(200, 0, 0, 0, 0);
        @(posedge clk);
        #2;
        chk(rd0 == 32'(m_cnt[0][6]), "R10 next-cycle new", rd0, m_cnt[0][6]);
        @(negedge clk);
        frame_done = 1'b0;

        // R4 saturation on the narrow instance
        for (int n = 0; n < 20; n++) send(1000, 8'h01, 0, 0, 0);
        read_all("");
        chk(rd1 == 0, "R9 idx15 narrow", rd1, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule